// File: doc/BRIEF.md
# Registered Command/Address Fanout Buffer

This block is the register stage that sits between a memory controller's command/address bus and the DRAM devices of a module. On every rising clock edge it captures the command/address word, the chip selects and the per-rank clock-enable and termination controls, then drives each captured command/address bit onto two output banks, A and B. A parameter lets the top few bits go to bank A only, which gives a mixed layout of duplicated bits and single-copy bits.

A static strap picks the chip-select layout. With the strap high, two chip selects are used and each one drives one output in bank A and one in bank B. With the strap low, four chip selects are used and each drives exactly one output. Chip selects are active low. When no chip select that belongs to the current layout is asserted, the command/address outputs keep their last value so that the DRAM-side wires do not toggle. Chip-select and control outputs are registered every cycle. An active-low reset clears all state.

Top module: `ca_fanout_buf`

## Requirements
- R1: A command/address word applied before a rising edge, with at least one chip select of the current layout at 0, appears on both bank A and bank B outputs after that edge and stays there until a later capture.
- R2: With SPLIT_W > 0, the top SPLIT_W bits of the word are driven on bank A only. The same bit positions on bank B are driven 0. The lower CA_W-SPLIT_W bits go to both banks.
- R3: With the strap at 1 (two-select layout), chip-select input 0 drives output bit 0 of bank A and of bank B, and input 1 drives output bit 1 of both banks. Inputs 2 and 3 have no effect on any output.
- R4: With the strap at 0 (four-select layout), chip-select inputs 0 and 1 drive bank A bits 0 and 1, and inputs 2 and 3 drive bank B bits 0 and 1.
- R5: If every chip select of the current layout is 1 before an edge, the command/address outputs of both banks keep their previous value after that edge. In the two-select layout, a 0 on input 2 or 3 does not count as a selection.
- R6: The clock-enable and termination control bits are registered and forwarded to their outputs with one cycle of latency on every edge, whether or not a chip select is asserted.
- R7: While reset is low, every chip-select output is 1 and all command/address, clock-enable and termination outputs are 0. After reset the hold value starts from 0.
- R8: Chip-select outputs follow their inputs with one cycle of latency on every edge, even while the command/address outputs are being held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| pair_cs_mode | input | 1 | Layout strap: 1 = two selects, each duplicated; 0 = four selects, single copy |
| cs_n_in | input | 4 | Active-low chip selects; bits 3:2 are used only when the strap is 0 |
| ca_in | input | CA_W | Command/address word |
| cke_in | input | CTL_N | Clock-enable controls |
| odt_in | input | CTL_N | On-die-termination controls |
| ca_a | output | CA_W | Command/address, bank A |
| ca_b | output | CA_W | Command/address, bank B (top SPLIT_W bits driven 0) |
| cs_a_n | output | 2 | Chip-select outputs, bank A |
| cs_b_n | output | 2 | Chip-select outputs, bank B |
| cke_q | output | CTL_N | Registered clock-enable controls |
| odt_q | output | CTL_N | Registered termination controls |

## Verification
The bench drives all sixteen chip-select combinations many times, each with a different command/address word and control bits. It does this into three copies of the block that share one set of inputs: one copy in the two-select layout, one in the four-select layout, and one four-select copy with two bank-A-only bits. The patterns where only inputs 2 or 3 are low tell the two layouts apart: the four-select copy loads the new word while the two-select copy must keep its old word. The all-high pattern checks the hold and, in the same cycle, checks that the chip-select and control outputs still move. A reset in the middle of the sweep checks the predefined output values and checks that the hold value starts again from zero.

// File: rtl/ca_buf_pkg.sv
package ca_buf_pkg;

  localparam int CS_IN_W  = 4;
  localparam int CS_OUT_W = 2;

  // True when a chip select that belongs to the chosen layout is low.
  function automatic logic sel_active(input logic [CS_IN_W-1:0] cs_n,
                                      input logic               pair_mode);
    if (pair_mode) return ~&cs_n[1:0];
    return ~&cs_n;
  endfunction

  // Output chip selects packed as {bank B, bank A}.
  function automatic logic [2*CS_OUT_W-1:0] cs_route(input logic [CS_IN_W-1:0] cs_n,
                                                     input logic               pair_mode);
    if (pair_mode) return {cs_n[1:0], cs_n[1:0]};
    return cs_n;
  endfunction

endpackage

// File: rtl/ca_cs_route.sv
module ca_cs_route
  import ca_buf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pair_mode,
  input  logic [CS_IN_W-1:0]  cs_n_in,
  output logic                sel_any,
  output logic [CS_OUT_W-1:0] cs_a_n,
  output logic [CS_OUT_W-1:0] cs_b_n
);

  logic [2*CS_OUT_W-1:0] cs_next;

  assign sel_any = sel_active(cs_n_in, pair_mode);
  assign cs_next = cs_route(cs_n_in, pair_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_a_n <= '1;
      cs_b_n <= '1;
    end else begin
      cs_a_n <= cs_next[CS_OUT_W-1:0];
      cs_b_n <= cs_next[2*CS_OUT_W-1:CS_OUT_W];
    end
  end

  // R7: chip selects deasserted under reset
  a_r7_cs_reset: assert property (@(posedge clk)
    !rst_n |=> (cs_a_n == '1) && (cs_b_n == '1));

  // R8: bank A always tracks inputs 1:0 on every edge
  a_r8_cs_every_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cs_a_n == $past(cs_n_in[1:0]));

  // R3: two-select layout duplicates into bank B
  a_r3_pair_dup: assert property (@(posedge clk) disable iff (!rst_n)
    pair_mode |=> cs_b_n == $past(cs_n_in[1:0]));

  // R4: four-select layout sends inputs 3:2 to bank B
  a_r4_quad_direct: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode |=> cs_b_n == $past(cs_n_in[3:2]));

endmodule

// File: rtl/ca_hold_bank.sv
module ca_hold_bank #(
  parameter int CA_W    = 8,
  parameter int SPLIT_W = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CA_W-1:0] ca_in,
  output logic [CA_W-1:0] ca_a,
  output logic [CA_W-1:0] ca_b
);

  localparam int DUP_W = CA_W - SPLIT_W;

  logic [CA_W-1:0] ca_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ca_q <= '0;
    else if (load) ca_q <= ca_in;
  end

  assign ca_a = ca_q;

  generate
    if (SPLIT_W > 0) begin : g_split
      assign ca_b = {{SPLIT_W{1'b0}}, ca_q[DUP_W-1:0]};
    end else begin : g_full
      assign ca_b = ca_q;
    end
  endgenerate

  // R1: selected cycle captures the word
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ca_a == $past(ca_in));

  // R5: no selection, no change on either bank
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ca_a) && $stable(ca_b));

  // R2: lower bits identical on both banks
  a_r2_dup_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ca_a[DUP_W-1:0] == ca_b[DUP_W-1:0]);

  // R7: cleared under reset
  a_r7_ca_reset: assert property (@(posedge clk)
    !rst_n |=> (ca_a == '0) && (ca_b == '0));

endmodule

// File: rtl/ca_ctl_pipe.sv
module ca_ctl_pipe #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R6: one-cycle forward on every edge
  a_r6_ctl_forward: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> q == $past(d));

  // R7: controls low under reset
  a_r7_ctl_reset: assert property (@(posedge clk)
    !rst_n |=> q == '0);

endmodule

// File: rtl/ca_fanout_buf.sv
module ca_fanout_buf
  import ca_buf_pkg::*;
#(
  parameter int CA_W    = 8,
  parameter int SPLIT_W = 0,
  parameter int CTL_N   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pair_cs_mode,
  input  logic [CS_IN_W-1:0]  cs_n_in,
  input  logic [CA_W-1:0]     ca_in,
  input  logic [CTL_N-1:0]    cke_in,
  input  logic [CTL_N-1:0]    odt_in,
  output logic [CA_W-1:0]     ca_a,
  output logic [CA_W-1:0]     ca_b,
  output logic [CS_OUT_W-1:0] cs_a_n,
  output logic [CS_OUT_W-1:0] cs_b_n,
  output logic [CTL_N-1:0]    cke_q,
  output logic [CTL_N-1:0]    odt_q
);

  localparam int CTL_W = 2 * CTL_N;

  logic             sel_any;
  logic [CTL_W-1:0] ctl_q;

  ca_cs_route u_cs (
    .clk       (clk),
    .rst_n     (rst_n),
    .pair_mode (pair_cs_mode),
    .cs_n_in   (cs_n_in),
    .sel_any   (sel_any),
    .cs_a_n    (cs_a_n),
    .cs_b_n    (cs_b_n)
  );

  ca_hold_bank #(.CA_W(CA_W), .SPLIT_W(SPLIT_W)) u_ca (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sel_any),
    .ca_in (ca_in),
    .ca_a  (ca_a),
    .ca_b  (ca_b)
  );

  ca_ctl_pipe #(.W(CTL_W)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({odt_in, cke_in}),
    .q     (ctl_q)
  );

  assign cke_q = ctl_q[CTL_N-1:0];
  assign odt_q = ctl_q[CTL_W-1:CTL_N];

  // R5: in the two-select layout inputs 3:2 alone never load the word
  a_r5_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_cs_mode && (cs_n_in[1:0] == 2'b11)) |=> $stable(ca_a));

endmodule

// File: tb/test_ca_fanout_buf.sv
module test_ca_fanout_buf;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cs_n_in = 4'hF;
  logic [7:0] ca_in = '0;
  logic [1:0] cke_in = '0;
  logic [1:0] odt_in = '0;

  logic [7:0] p_ca_a, p_ca_b, q_ca_a, q_ca_b, s_ca_a, s_ca_b;
  logic [1:0] p_cs_a, p_cs_b, q_cs_a, q_cs_b, s_cs_a, s_cs_b;
  logic [1:0] p_cke, p_odt, q_cke, q_odt, s_cke, s_odt;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_pair = '0;
  logic [7:0] exp_quad = '0;

  always #5 clk = ~clk;

  ca_fanout_buf #(.CA_W(8), .SPLIT_W(0), .CTL_N(2)) i_ca_fanout_buf (
    .clk(clk), .rst_n(rst_n), .pair_cs_mode(1'b1), .cs_n_in(cs_n_in),
    .ca_in(ca_in), .cke_in(cke_in), .odt_in(odt_in),
    .ca_a(p_ca_a), .ca_b(p_ca_b), .cs_a_n(p_cs_a), .cs_b_n(p_cs_b),
    .cke_q(p_cke), .odt_q(p_odt));

  ca_fanout_buf #(.CA_W(8), .SPLIT_W(0), .CTL_N(2)) i_ca_fanout_buf_quad (
    .clk(clk), .rst_n(rst_n), .pair_cs_mode(1'b0), .cs_n_in(cs_n_in),
    .ca_in(ca_in), .cke_in(cke_in), .odt_in(odt_in),
    .ca_a(q_ca_a), .ca_b(q_ca_b), .cs_a_n(q_cs_a), .cs_b_n(q_cs_b),
    .cke_q(q_cke), .odt_q(q_odt));

  ca_fanout_buf #(.CA_W(8), .SPLIT_W(2), .CTL_N(2)) i_ca_fanout_buf_split (
    .clk(clk), .rst_n(rst_n), .pair_cs_mode(1'b0), .cs_n_in(cs_n_in),
    .ca_in(ca_in), .cke_in(cke_in), .odt_in(odt_in),
    .ca_a(s_ca_a), .ca_b(s_ca_b), .cs_a_n(s_cs_a), .cs_b_n(s_cs_b),
    .cke_q(s_cke), .odt_q(s_odt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_reset();
    chk("R7 pair ca_a", 32'(p_ca_a), 0);
    chk("R7 pair ca_b", 32'(p_ca_b), 0);
    chk("R7 pair cs_a", 32'(p_cs_a), 3);
    chk("R7 pair cs_b", 32'(p_cs_b), 3);
    chk("R7 quad cs_b", 32'(q_cs_b), 3);
    chk("R7 split ca_a", 32'(s_ca_a), 0);
    chk("R7 ctl", 32'({p_odt, p_cke, q_odt, q_cke}), 0);
  endtask

  task automatic step(input logic [3:0] cs, input logic [7:0] ca,
                      input logic [1:0] cke, input logic [1:0] odt);
    cs_n_in = cs; ca_in = ca; cke_in = cke; odt_in = odt;
    if (cs[1:0] != 2'b11) exp_pair = ca;
    if (cs != 4'hF)       exp_quad = ca;
    @(negedge clk);
    chk("R1/R5 pair ca_a", 32'(p_ca_a), 32'(exp_pair));
    chk("R1/R5 pair ca_b", 32'(p_ca_b), 32'(exp_pair));
    chk("R3/R8 pair cs_a", 32'(p_cs_a), 32'(cs[1:0]));
    chk("R3/R8 pair cs_b", 32'(p_cs_b), 32'(cs[1:0]));
    chk("R1/R5 quad ca_a", 32'(q_ca_a), 32'(exp_quad));
    chk("R1/R5 quad ca_b", 32'(q_ca_b), 32'(exp_quad));
    chk("R4/R8 quad cs_a", 32'(q_cs_a), 32'(cs[1:0]));
    chk("R4/R8 quad cs_b", 32'(q_cs_b), 32'(cs[3:2]));
    chk("R2 split ca_a", 32'(s_ca_a), 32'(exp_quad));
    chk("R2 split ca_b", 32'(s_ca_b), 32'({2'b00, exp_quad[5:0]}));
    chk("R6 pair cke", 32'(p_cke), 32'(cke));
    chk("R6 pair odt", 32'(p_odt), 32'(odt));
    chk("R6 quad ctl", 32'({q_odt, q_cke}), 32'({odt, cke}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_reset();
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) begin
      step(4'(i), 8'(i * 37 + 5), 2'(i >> 4), 2'(i >> 6));
    end
    // Only upper selects low: quad loads, pair holds (R5)
    step(4'b0011, 8'hA5, 2'b01, 2'b10);
    step(4'b1111, 8'h3C, 2'b10, 2'b01);
    rst_n = 1'b0;
    exp_pair = '0;
    exp_quad = '0;
    @(negedge clk);
    chk_reset();
    rst_n = 1'b1;
    step(4'b1111, 8'hFF, 2'b11, 2'b11);
    step(4'b1110, 8'h5A, 2'b00, 2'b11);
    step(4'b0111, 8'hC3, 2'b11, 2'b00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule